// File: doc/BRIEF.md
# Reset-Moded Address Space Decoder

This block turns a 32-bit bus address into a set of one-hot region selects for a processor with two on-chip memory banks, named X and Y. Each bank has a 24 KB ROM page and a 4 KB RAM page. The other regions are a peripheral register window, four 16 MB external chip-select areas and an unmapped flag. For the selected region it also gives the offset of the address from that region's base. The decode is purely combinational from the address and the valid strobe. The only stored state is a single boot-mode bit.

The boot-mode bit is captured from two strap pins while synchronous reset is held. It is frozen once reset is released. With both straps low the block runs in internal-boot mode. In that mode the bottom 128 KB of the space holds the on-chip ROM and RAM pages, so the vector area falls inside X ROM. The rest of the low 16 MB reaches no memory. With any other strap combination the block runs in external-boot mode. In that mode the whole low 16 MB, vectors included, goes to external area 0. On-chip pages are not mapped in external-boot mode.

Top module: `addr_space_decoder`

## Requirements
- R1: The boot mode is internal exactly when both strap_a and strap_b are low on the last clock edge at which rst is high. Straps 01, 10 and 11 give external mode.
- R2: After reset is released, the boot mode does not change whatever the strap pins do. It can be seen at the ports by decoding address 0x00000000.
- R3: In internal mode, the on-chip regions and their offsets (address minus base) are:
  - X ROM: 0x00000000 to 0x00005FFF
  - X RAM: 0x00006000 to 0x00006FFF
  - Y ROM: 0x00010000 to 0x00015FFF
  - Y RAM: 0x00016000 to 0x00016FFF
- R4: In internal mode, every other address below 0x01000000 asserts unmapped. No external select is asserted for any address below 0x01000000. This covers the gaps 0x7000 to 0xFFFF and 0x17000 to 0x1FFFF, and everything from 0x20000 upwards.
- R5: In external mode, every address from 0x00000000 to 0x00FFFFFF asserts sel_ext[0], with offset equal to the address.
- R6: In both modes, 0x01000000 to 0x03FFFFFF asserts sel_ext[n], where n is address bits 25:24 (1 to 3). The offset is address bits 23:0, zero-extended.
- R7: In both modes, 0x0C000000 to 0x0DFFFFFF asserts sel_periph, with offset equal to the address minus 0x0C000000.
- R8: Any valid address outside the ranges above asserts unmapped, with all selects low and offset 0.
- R9: When valid is low, every select, unmapped and offset are zero.
- R10: While valid is high, exactly one of the nine selects and unmapped is high. While valid is low, none is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while high |
| addr | input | 32 | Bus address |
| valid | input | 1 | Address strobe; outputs are zero when low |
| strap_a | input | 1 | Boot-mode strap pin A |
| strap_b | input | 1 | Boot-mode strap pin B |
| sel_xrom | output | 1 | X ROM select |
| sel_xram | output | 1 | X RAM select |
| sel_yrom | output | 1 | Y ROM select |
| sel_yram | output | 1 | Y RAM select |
| sel_periph | output | 1 | Peripheral register window select |
| sel_ext | output | 4 | External area selects, bit n for area n |
| unmapped | output | 1 | Valid address matched no region |
| offset | output | 32 | Address minus the base of the selected region |

## Verification
The boot-mode bit is the only state in the block. If it is latched or held wrongly, the map is wrong from the first valid access after reset. Address 0 then shows sel_ext[0] instead of sel_xrom, or the reverse. The gap addresses switch between unmapped and external area 0 in the same combinational cycle. For this reason the bench decodes low addresses right after each reset with every strap combination. It decodes them again after toggling the straps with reset low. Every other fault is combinational, so it shows in the same cycle as the address. It is caught by comparing the selects and the offset at window edges and at random addresses in both modes.

// File: rtl/asd_pkg.sv
package asd_pkg;

    localparam int ADDR_W      = 32;
    localparam int NUM_ONCHIP  = 4;
    localparam int NUM_EXT     = 4;
    localparam int EXT_AREA_LG = 24;

    localparam logic [ADDR_W-1:0] PERIPH_BASE = 32'h0C00_0000;
    localparam logic [ADDR_W:0]   PERIPH_SPAN = 33'h0_0200_0000;
    localparam logic [ADDR_W:0]   EXT_SPAN    = 33'h1 << EXT_AREA_LG;
    localparam logic [ADDR_W:0]   ROM_SPAN    = 33'h0_0000_6000;
    localparam logic [ADDR_W:0]   RAM_SPAN    = 33'h0_0000_1000;

    typedef enum logic [3:0] {
        RG_IDLE,
        RG_UNMAPPED,
        RG_XROM,
        RG_XRAM,
        RG_YROM,
        RG_YRAM,
        RG_PERIPH,
        RG_EXT0,
        RG_EXT1,
        RG_EXT2,
        RG_EXT3
    } region_e;

    typedef struct packed {
        region_e             region;
        logic [ADDR_W-1:0]   offset;
    } dec_result_t;

    // On-chip page index: 0 X ROM, 1 X RAM, 2 Y ROM, 3 Y RAM
    function automatic logic [ADDR_W-1:0] onchip_base(input int idx);
        case (idx)
            0:       return 32'h0000_0000;
            1:       return 32'h0000_6000;
            2:       return 32'h0001_0000;
            default: return 32'h0001_6000;
        endcase
    endfunction

    function automatic logic [ADDR_W:0] onchip_span(input int idx);
        return (idx % 2 == 0) ? ROM_SPAN : RAM_SPAN;
    endfunction

    function automatic region_e onchip_region(input int idx);
        case (idx)
            0:       return RG_XROM;
            1:       return RG_XRAM;
            2:       return RG_YROM;
            default: return RG_YRAM;
        endcase
    endfunction

    function automatic region_e ext_region(input int idx);
        case (idx)
            0:       return RG_EXT0;
            1:       return RG_EXT1;
            2:       return RG_EXT2;
            default: return RG_EXT3;
        endcase
    endfunction

endpackage

// File: rtl/asd_mode_latch.sv
module asd_mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic strap_a,
    input  logic strap_b,
    output logic boot_internal
);

    logic boot_int_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            boot_int_q <= ~(strap_a | strap_b);
        end
    end

    assign boot_internal = boot_int_q;

    // R1: the value held at release is the strap pair seen on the last reset edge
    a_r1_strap_capture: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (boot_int_q == ~($past(strap_a) | $past(strap_b))));

    // R2: no change while out of reset
    a_r2_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(boot_int_q));

endmodule

// File: rtl/asd_window.sv
module asd_window #(
    parameter int                AW   = 32,
    parameter logic [AW-1:0]     BASE = '0,
    parameter logic [AW:0]       SPAN = 1
) (
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW-1:0] offset
);

    localparam logic [AW:0] LO = {1'b0, BASE};
    localparam logic [AW:0] HI = LO + SPAN;

    logic [AW:0] addr_x;

    always_comb begin
        addr_x = {1'b0, addr};
        hit    = (addr_x >= LO) && (addr_x < HI);
        offset = addr - BASE;
    end

endmodule

// File: rtl/asd_select.sv
module asd_select
    import asd_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int N_ON  = NUM_ONCHIP,
    parameter int N_EXT = NUM_EXT
) (
    input  logic                      valid,
    input  logic                      boot_internal,
    input  logic [N_ON-1:0]           on_hit,
    input  logic [N_ON-1:0][AW-1:0]   on_off,
    input  logic [N_EXT-1:0]          ext_hit,
    input  logic [N_EXT-1:0][AW-1:0]  ext_off,
    input  logic                      per_hit,
    input  logic [AW-1:0]             per_off,
    output dec_result_t               result
);

    always_comb begin
        result.region = RG_IDLE;
        result.offset = '0;
        if (valid) begin
            result.region = RG_UNMAPPED;
            if (per_hit) begin
                result.region = RG_PERIPH;
                result.offset = per_off;
            end else if (boot_internal && ext_hit[0]) begin
                // low area is on-chip only; anything else there is a hole
                for (int i = 0; i < N_ON; i++) begin
                    if (on_hit[i]) begin
                        result.region = onchip_region(i);
                        result.offset = on_off[i];
                    end
                end
            end else begin
                for (int i = 0; i < N_EXT; i++) begin
                    if (ext_hit[i]) begin
                        result.region = ext_region(i);
                        result.offset = ext_off[i];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/addr_space_decoder.sv
module addr_space_decoder
    import asd_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int N_ON  = NUM_ONCHIP,
    parameter int N_EXT = NUM_EXT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr,
    input  logic             valid,
    input  logic             strap_a,
    input  logic             strap_b,
    output logic             sel_xrom,
    output logic             sel_xram,
    output logic             sel_yrom,
    output logic             sel_yram,
    output logic             sel_periph,
    output logic [N_EXT-1:0] sel_ext,
    output logic             unmapped,
    output logic [AW-1:0]    offset
);

    logic                     boot_internal;
    logic [N_ON-1:0]          on_hit;
    logic [N_ON-1:0][AW-1:0]  on_off;
    logic [N_EXT-1:0]         ext_hit;
    logic [N_EXT-1:0][AW-1:0] ext_off;
    logic                     per_hit;
    logic [AW-1:0]            per_off;
    dec_result_t              result;

    asd_mode_latch u_mode (
        .clk           (clk),
        .rst           (rst),
        .strap_a       (strap_a),
        .strap_b       (strap_b),
        .boot_internal (boot_internal)
    );

    for (genvar g = 0; g < N_ON; g++) begin : g_onchip
        asd_window #(
            .AW   (AW),
            .BASE (onchip_base(g)),
            .SPAN (onchip_span(g))
        ) u_win (
            .addr   (addr),
            .hit    (on_hit[g]),
            .offset (on_off[g])
        );
    end

    for (genvar g = 0; g < N_EXT; g++) begin : g_ext
        localparam logic [AW-1:0] EBASE = AW'(g) << EXT_AREA_LG;
        asd_window #(
            .AW   (AW),
            .BASE (EBASE),
            .SPAN (EXT_SPAN)
        ) u_win (
            .addr   (addr),
            .hit    (ext_hit[g]),
            .offset (ext_off[g])
        );
    end

    asd_window #(
        .AW   (AW),
        .BASE (PERIPH_BASE),
        .SPAN (PERIPH_SPAN)
    ) u_periph (
        .addr   (addr),
        .hit    (per_hit),
        .offset (per_off)
    );

    asd_select #(
        .AW    (AW),
        .N_ON  (N_ON),
        .N_EXT (N_EXT)
    ) u_sel (
        .valid         (valid),
        .boot_internal (boot_internal),
        .on_hit        (on_hit),
        .on_off        (on_off),
        .ext_hit       (ext_hit),
        .ext_off       (ext_off),
        .per_hit       (per_hit),
        .per_off       (per_off),
        .result        (result)
    );

    always_comb begin
        sel_xrom   = (result.region == RG_XROM);
        sel_xram   = (result.region == RG_XRAM);
        sel_yrom   = (result.region == RG_YROM);
        sel_yram   = (result.region == RG_YRAM);
        sel_periph = (result.region == RG_PERIPH);
        unmapped   = (result.region == RG_UNMAPPED);
        for (int i = 0; i < N_EXT; i++) begin
            sel_ext[i] = (result.region == ext_region(i));
        end
        offset = result.offset;
    end

    // R10: one region at a time, and exactly one for a valid address
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        valid |-> ($countones({sel_xrom, sel_xram, sel_yrom, sel_yram,
                               sel_periph, sel_ext, unmapped}) == 1));

    // R9: idle bus drives nothing
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !valid |-> ({sel_xrom, sel_xram, sel_yrom, sel_yram, sel_periph,
                     sel_ext, unmapped} == '0 && offset == '0));

    // R4: internal boot never reaches external memory below 16 MB
    a_r4_low_blocked: assert property (@(posedge clk) disable iff (rst)
        (valid && boot_internal && addr[AW-1:EXT_AREA_LG] == '0) |-> (sel_ext == '0));

    // R7: peripheral window in either mode
    a_r7_periph_window: assert property (@(posedge clk) disable iff (rst)
        (valid && addr >= PERIPH_BASE && addr <= 32'h0DFF_FFFF) |-> sel_periph);

    // R8: an unmapped access reports a zero offset
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (offset == '0));

endmodule

// File: tb/addr_space_decoder_tb.sv
`timescale 1ns/1ps
module addr_space_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = '0;
    logic        valid = 1'b0;
    logic        strap_a = 1'b0;
    logic        strap_b = 1'b0;
    logic        sel_xrom, sel_xram, sel_yrom, sel_yram, sel_periph, unmapped;
    logic [3:0]  sel_ext;
    logic [31:0] offset;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    addr_space_decoder u_dut (
        .clk (clk), .rst (rst), .addr (addr), .valid (valid),
        .strap_a (strap_a), .strap_b (strap_b),
        .sel_xrom (sel_xrom), .sel_xram (sel_xram), .sel_yrom (sel_yrom),
        .sel_yram (sel_yram), .sel_periph (sel_periph), .sel_ext (sel_ext),
        .unmapped (unmapped), .offset (offset)
    );

    // Packed view: {xrom,xram,yrom,yram,periph,ext3,ext2,ext1,ext0,unmapped}
    localparam logic [9:0] S_XROM = 10'b1000000000;
    localparam logic [9:0] S_XRAM = 10'b0100000000;
    localparam logic [9:0] S_YROM = 10'b0010000000;
    localparam logic [9:0] S_YRAM = 10'b0001000000;
    localparam logic [9:0] S_PER  = 10'b0000100000;
    localparam logic [9:0] S_UNM  = 10'b0000000001;

    function automatic logic [41:0] model(input logic [31:0] a, input bit v, input bit intl);
        logic [9:0]  s;
        logic [31:0] o;
        s = '0; o = '0;
        if (v) begin
            s = S_UNM;
            if (a >= 32'h0C00_0000 && a < 32'h0E00_0000) begin
                s = S_PER; o = a - 32'h0C00_0000;
            end else if (a < 32'h0100_0000 && intl) begin
                if (a < 32'h6000)                        begin s = S_XROM; o = a; end
                else if (a < 32'h7000)                   begin s = S_XRAM; o = a - 32'h6000; end
                else if (a >= 32'h10000 && a < 32'h16000) begin s = S_YROM; o = a - 32'h10000; end
                else if (a >= 32'h16000 && a < 32'h17000) begin s = S_YRAM; o = a - 32'h16000; end
            end else if (a < 32'h0400_0000) begin
                s = 10'b0000000010 << a[25:24];
                o = {8'h00, a[23:0]};
            end
        end
        return {s, o};
    endfunction

    function automatic string tag_of(input logic [31:0] a, input bit v, input bit intl);
        if (!v) return "R9";
        if (a >= 32'h0C00_0000 && a < 32'h0E00_0000) return "R7";
        if (a < 32'h0100_0000) begin
            if (!intl) return "R5";
            if (a < 32'h7000 || (a >= 32'h10000 && a < 32'h17000)) return "R3";
            return "R4";
        end
        if (a < 32'h0400_0000) return "R6";
        return "R8";
    endfunction

    task automatic probe(input logic [31:0] a, input bit v, input bit intl, input string note);
        logic [41:0] exp, got;
        @(negedge clk);
        addr = a; valid = v;
        #1;
        exp = model(a, v, intl);
        got = {sel_xrom, sel_xram, sel_yrom, sel_yram, sel_periph, sel_ext, unmapped, offset};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s addr=%h sel got=%b exp=%b off got=%h exp=%h",
                     tag_of(a, v, intl), note, a, got[41:32], exp[41:32], got[31:0], exp[31:0]);
        end
        if (v) begin
            checks++;
            if ($countones(got[41:32]) != 1) begin
                errors++;
                $display("FAIL R10 addr=%h sel got=%b exp one bit set", a, got[41:32]);
            end
        end
    endtask

    task automatic do_reset(input bit sa, input bit sb);
        @(negedge clk);
        rst = 1'b1; valid = 1'b0;
        strap_a = ~sa; strap_b = ~sb;
        repeat (2) @(negedge clk);
        strap_a = sa; strap_b = sb;
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] rand_addr();
        case ($urandom % 8)
            0, 1: return $urandom % 32'h0002_0000;
            2:    return $urandom % 32'h0100_0000;
            3:    return $urandom % 32'h0400_0000;
            4:    return 32'h0BF0_0000 + ($urandom % 32'h0220_0000);
            5:    return 32'h03F0_0000 + ($urandom % 32'h0020_0000);
            default: return $urandom;
        endcase
    endfunction

    task automatic directed(input bit intl);
        // R3 window edges
        probe(32'h0000_0000, 1, intl, "vector base");
        probe(32'h0000_03FC, 1, intl, "vector end");
        probe(32'h0000_5FFF, 1, intl, "xrom top");
        probe(32'h0000_6000, 1, intl, "xram base");
        probe(32'h0000_6FFF, 1, intl, "xram top");
        probe(32'h0000_7000, 1, intl, "gap1 start");
        probe(32'h0000_FFFF, 1, intl, "gap1 end");
        probe(32'h0001_0000, 1, intl, "yrom base");
        probe(32'h0001_5FFF, 1, intl, "yrom top");
        probe(32'h0001_6000, 1, intl, "yram base");
        probe(32'h0001_6FFF, 1, intl, "yram top");
        probe(32'h0001_7000, 1, intl, "gap2 start");
        probe(32'h0002_0000, 1, intl, "past window");
        probe(32'h00FF_FFFF, 1, intl, "low area top");
        // R6 external areas
        probe(32'h0100_0000, 1, intl, "area1 base");
        probe(32'h02AB_CDEF, 1, intl, "area2 mid");
        probe(32'h03FF_FFFF, 1, intl, "area3 top");
        probe(32'h0400_0000, 1, intl, "past ext");
        // R7 peripheral edges
        probe(32'h0BFF_FFFF, 1, intl, "below periph");
        probe(32'h0C00_0000, 1, intl, "periph base");
        probe(32'h0DFF_FFFF, 1, intl, "periph top");
        probe(32'h0E00_0000, 1, intl, "above periph");
        probe(32'hFFFF_FFFF, 1, intl, "top of space");
        // R9 idle
        probe(32'h0000_6000, 0, intl, "idle");
        probe(32'h0C00_0010, 0, intl, "idle periph");
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));

        // reset state: R9 with valid low
        do_reset(1'b0, 1'b0);
        probe(32'h0000_0000, 0, 1, "reset state");

        // R1 internal with straps 00
        probe(32'h0000_0000, 1, 1, "R1 straps 00");
        directed(1);
        for (int i = 0; i < 3000; i++) probe(rand_addr(), ($urandom % 8) != 0, 1, "random");

        // R2: straps change after release, mode stays internal
        @(negedge clk); strap_a = 1'b1; strap_b = 1'b1;
        repeat (5) @(negedge clk);
        probe(32'h0000_0000, 1, 1, "R2 straps 11 after release");
        @(negedge clk); strap_a = 1'b1; strap_b = 1'b0;
        probe(32'h0000_8000, 1, 1, "R2 straps 10 after release");

        // R1 external combinations
        do_reset(1'b1, 1'b0);
        probe(32'h0000_0000, 1, 0, "R1 straps 10");
        do_reset(1'b0, 1'b1);
        probe(32'h0000_0000, 1, 0, "R1 straps 01");
        do_reset(1'b1, 1'b1);
        probe(32'h0000_0000, 1, 0, "R1 straps 11");
        directed(0);
        for (int i = 0; i < 3000; i++) probe(rand_addr(), ($urandom % 8) != 0, 0, "random");

        // R2: external mode held when straps go low after release
        @(negedge clk); strap_a = 1'b0; strap_b = 1'b0;
        repeat (5) @(negedge clk);
        probe(32'h0000_0000, 1, 0, "R2 straps 00 after release");

        // back to internal via a fresh reset (R1)
        do_reset(1'b0, 1'b0);
        probe(32'h0001_6004, 1, 1, "R1 re-reset to 00");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired before the bench completed");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule